// File: doc/BRIEF.md
# Multi-Mode Double-Precision Min/Max Unit

This block takes two IEEE 754 binary64 operands and a 4-bit mode code and returns one of the two operands as the minimum or maximum. Any NaN it returns is first made quiet. A single datapath covers sixteen semantics. The mode chooses min or max and chooses plain or magnitude comparison. It also chooses one of four policies for NaNs and signed zeros: a 2008-style number-preferring rule, a 2019-style NaN-propagating rule, a 2019-style number-preferring rule, and a C-style ternary compare.

It is intended to sit in a floating-point execution pipe as a single-cycle stage. Operands and mode are presented with a valid strobe. The result and a valid flag come out of a register one clock later. While the strobe is low, the result register keeps its last value.

Top module: `fp_minmax_unit`

## Requirements
- R1: Mode encoding: bit 3 = 1 selects max (0 selects min), bit 2 = 1 selects magnitude comparison, and bits 1:0 select the policy (00 = 2008 number rule, 01 = 2019 NaN-propagating rule, 10 = 2019 number rule, 11 = C-style). C-style min returns A if A < B, otherwise B. C-style max returns A if A > B, otherwise B. Signed zeros compare equal here, and any NaN operand makes the compare false, so B is returned.
- R2: Policy 00 orders -0.0 strictly below +0.0. If either operand is a signalling NaN (exponent all ones, fraction bit 51 clear, fraction nonzero), it returns that NaN quieted, checking A first. If both are quiet NaNs, it returns A. If exactly one is a quiet NaN, it returns the other operand.
- R3: Policy 01 returns a NaN whenever either operand is NaN, taking A's NaN first and quieting it. It orders -0.0 below +0.0.
- R4: Policy 10 treats signalling and quiet NaNs alike. It returns the other operand when exactly one operand is NaN, returns A (quieted) when both are NaN, and orders -0.0 below +0.0.
- R5: With bit 2 set and no NaN operand, if the magnitudes (bits 62:0) differ, the operand of smaller magnitude is returned for min and the operand of larger magnitude for max.
- R6: With bit 2 set and equal magnitudes, the result equals the base policy applied to the original operands.
- R7: With bit 2 set and any NaN operand, the result equals the base policy applied to the original operands.
- R8: Every NaN result has fraction bit 51 set, and all its other bits are unchanged from the chosen operand.
- R9: valid_o is high exactly one clock after a cycle with valid_i high. The matching result is on result_o in that same cycle.
- R10: After a cycle with valid_i low, result_o keeps its previous value, whatever the data inputs do.
- R11: After synchronous reset, result_o and valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| a_i | input | 64 | Operand A, binary64 |
| b_i | input | 64 | Operand B, binary64 |
| mode_i | input | 4 | Max/min, magnitude and policy select |
| result_o | output | 64 | Selected operand, NaNs quieted |
| valid_o | output | 1 | Result is valid |

## Verification
Magnitude comparison and NaN handling can land on the same operation. When a magnitude mode sees a signalling NaN, the magnitude path must step aside, the base policy picks the operand, and the output stage must still quiet it. Equal-magnitude pairs such as -3.0 against +3.0, or -0.0 against +0.0, trigger the tie fallback, and that fallback interacts with signed-zero ordering. The bench drives these overlaps directly and also sweeps all sixteen modes over a grid of zeros, infinities, finite values and both NaN kinds. Each result is judged against a reference built in the bench on real-number comparison plus explicit NaN and zero rules.

// File: rtl/fmm_pkg.sv
`timescale 1ns/1ps
package fmm_pkg;
  localparam int MODE_W       = 4;
  localparam int MODE_MAX_BIT = 3;
  localparam int MODE_MAG_BIT = 2;

  typedef enum logic [1:0] {
    POL_NUM08 = 2'b00,
    POL_MIN19 = 2'b01,
    POL_NUM19 = 2'b10,
    POL_CMP   = 2'b11
  } policy_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fp_class_t;
endpackage

// File: rtl/fmm_classify.sv
`timescale 1ns/1ps
module fmm_classify
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  output fp_class_t             cls_o,
  output logic [EXP_W+FRAC_W:0] key_o
);
  localparam int TOP = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  assign exp_f    = val_i[TOP-1:FRAC_W];
  assign frac_f   = val_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls_o.is_nan  = exp_ones & frac_nz;
    cls_o.is_snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls_o.is_zero = ~|val_i[TOP-1:0];
  end

  // Monotone unsigned key: negatives inverted, positives get the top bit set.
  // This places -0.0 directly below +0.0.
  always_comb begin
    if (val_i[TOP]) key_o = ~val_i;
    else            key_o = {1'b1, val_i[TOP-1:0]};
  end
endmodule

// File: rtl/fmm_mag_stage.sv
`timescale 1ns/1ps
module fmm_mag_stage #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  logic                  a_nan_i,
  input  logic                  b_nan_i,
  input  logic                  is_max_i,
  output logic                  decided_o,
  output logic [EXP_W+FRAC_W:0] res_o
);
  localparam int TOP = EXP_W + FRAC_W;

  logic [TOP-1:0] mag_a;
  logic [TOP-1:0] mag_b;
  logic           a_smaller;

  assign mag_a     = a_i[TOP-1:0];
  assign mag_b     = b_i[TOP-1:0];
  assign a_smaller = mag_a < mag_b;
  assign decided_o = ~a_nan_i & ~b_nan_i & (mag_a != mag_b);

  always_comb begin
    if (is_max_i) res_o = a_smaller ? b_i : a_i;
    else          res_o = a_smaller ? a_i : b_i;
  end
endmodule

// File: rtl/fmm_base_policy.sv
`timescale 1ns/1ps
module fmm_base_policy
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  logic [EXP_W+FRAC_W:0] key_a_i,
  input  logic [EXP_W+FRAC_W:0] key_b_i,
  input  fp_class_t             cls_a_i,
  input  fp_class_t             cls_b_i,
  input  logic                  is_max_i,
  input  policy_e               policy_i,
  output logic [EXP_W+FRAC_W:0] res_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic         key_lt;
  logic         key_gt;
  logic         any_nan;
  logic         both_nan;
  logic         both_zero;
  logic         c_take_a;
  logic [W-1:0] ordered;

  assign key_lt    = key_a_i < key_b_i;
  assign key_gt    = key_a_i > key_b_i;
  assign any_nan   = cls_a_i.is_nan | cls_b_i.is_nan;
  assign both_nan  = cls_a_i.is_nan & cls_b_i.is_nan;
  assign both_zero = cls_a_i.is_zero & cls_b_i.is_zero;

  // Total order with -0.0 below +0.0, used by three of the four policies
  always_comb begin
    if (is_max_i) ordered = key_lt ? b_i : a_i;
    else          ordered = key_lt ? a_i : b_i;
  end

  // Plain relational compare: unordered and signed-zero pairs are false
  always_comb begin
    if (any_nan || both_zero) c_take_a = 1'b0;
    else if (is_max_i)        c_take_a = key_gt;
    else                      c_take_a = key_lt;
  end

  always_comb begin
    res_o = ordered;
    unique case (policy_i)
      POL_CMP: res_o = c_take_a ? a_i : b_i;
      POL_MIN19: begin
        if (cls_a_i.is_nan)      res_o = a_i;
        else if (cls_b_i.is_nan) res_o = b_i;
      end
      POL_NUM08: begin
        if (cls_a_i.is_snan)      res_o = a_i;
        else if (cls_b_i.is_snan) res_o = b_i;
        else if (both_nan)        res_o = a_i;
        else if (cls_a_i.is_nan)  res_o = b_i;
        else if (cls_b_i.is_nan)  res_o = a_i;
      end
      POL_NUM19: begin
        if (both_nan)            res_o = a_i;
        else if (cls_a_i.is_nan) res_o = b_i;
        else if (cls_b_i.is_nan) res_o = a_i;
      end
      default: res_o = ordered;
    endcase
  end
endmodule

// File: rtl/fp_minmax_unit.sv
`timescale 1ns/1ps
module fp_minmax_unit
  import fmm_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic [EXP_W+FRAC_W:0]   a_i,
  input  logic [EXP_W+FRAC_W:0]   b_i,
  input  logic [MODE_W-1:0]       mode_i,
  output logic [EXP_W+FRAC_W:0]   result_o,
  output logic                    valid_o
);
  localparam int W   = EXP_W + FRAC_W + 1;
  localparam int TOP = W - 1;
  localparam int N_OP = 2;

  logic [W-1:0] opnd [N_OP];
  logic [W-1:0] key  [N_OP];
  fp_class_t    cls  [N_OP];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < N_OP; i++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val_i (opnd[i]),
      .cls_o (cls[i]),
      .key_o (key[i])
    );
  end

  logic    is_max;
  logic    mag_en;
  policy_e policy;

  assign is_max = mode_i[MODE_MAX_BIT];
  assign mag_en = mode_i[MODE_MAG_BIT];
  assign policy = policy_e'(mode_i[1:0]);

  logic [W-1:0] base_res;
  logic [W-1:0] mag_res;
  logic         mag_decided;

  fmm_base_policy #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_base (
    .a_i      (opnd[0]),
    .b_i      (opnd[1]),
    .key_a_i  (key[0]),
    .key_b_i  (key[1]),
    .cls_a_i  (cls[0]),
    .cls_b_i  (cls[1]),
    .is_max_i (is_max),
    .policy_i (policy),
    .res_o    (base_res)
  );

  fmm_mag_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mag (
    .a_i       (opnd[0]),
    .b_i       (opnd[1]),
    .a_nan_i   (cls[0].is_nan),
    .b_nan_i   (cls[1].is_nan),
    .is_max_i  (is_max),
    .decided_o (mag_decided),
    .res_o     (mag_res)
  );

  logic [W-1:0] picked;
  logic         picked_nan;
  logic [W-1:0] quieted;

  assign picked     = (mag_en && mag_decided) ? mag_res : base_res;
  assign picked_nan = (&picked[TOP-1:FRAC_W]) & (|picked[FRAC_W-1:0]);

  always_comb begin
    quieted = picked;
    if (picked_nan) quieted[FRAC_W-1] = 1'b1;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result_o <= '0;
        valid_o  <= 1'b0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) result_o <= quieted;
      end
    end
  end else begin : g_comb
    assign result_o = quieted;
    assign valid_o  = valid_i;
  end
endmodule

// File: rtl/fmm_checker.sv
`timescale 1ns/1ps
module fmm_checker #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  valid_i,
  input logic [EXP_W+FRAC_W:0] a_i,
  input logic [EXP_W+FRAC_W:0] b_i,
  input logic [3:0]            mode_i,
  input logic [EXP_W+FRAC_W:0] result_o,
  input logic                  valid_o
);
  localparam int TOP = EXP_W + FRAC_W;

  logic a_nan, b_nan, out_nan;
  assign a_nan   = (&a_i[TOP-1:FRAC_W]) & (|a_i[FRAC_W-1:0]);
  assign b_nan   = (&b_i[TOP-1:FRAC_W]) & (|b_i[FRAC_W-1:0]);
  assign out_nan = (&result_o[TOP-1:FRAC_W]) & (|result_o[FRAC_W-1:0]);

  if (REG_OUT) begin : g_chk
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_o);
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !valid_o);
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(result_o));
    p_nan_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (valid_o && out_nan) |-> result_o[FRAC_W-1]);
    p_min19_nan_r3: assert property (@(posedge clk) disable iff (rst)
      (valid_i && mode_i[1:0] == 2'b01 && (a_nan || b_nan)) |=> out_nan);
    p_num19_single_r4: assert property (@(posedge clk) disable iff (rst)
      (valid_i && mode_i[2:0] == 3'b010 && a_nan && !b_nan) |=> result_o == $past(b_i));
    p_reset_clear_r11: assert property (@(posedge clk)
      $fell(rst) |-> (!valid_o && result_o == '0));
  end
endmodule

bind fp_minmax_unit fmm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .mode_i   (mode_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/fp_minmax_unit_tb.sv
`timescale 1ns/1ps
module fp_minmax_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [3:0]  mode_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [63:0] P0   = 64'h0000000000000000;
  localparam logic [63:0] N0   = 64'h8000000000000000;
  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] P3   = 64'h4008000000000000;
  localparam logic [63:0] N3   = 64'hC008000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] QNP  = 64'h7FF8000000000123;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] SNN  = 64'hFFF4000000000000;

  always #2 clk = ~clk;

  fp_minmax_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .mode_i(mode_i), .result_o(result_o), .valid_o(valid_o)
  );

  // ---------------- reference model ----------------
  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic logic [63:0] quiet(input logic [63:0] x);
    return is_nan(x) ? (x | 64'h0008000000000000) : x;
  endfunction
  function automatic logic [63:0] ordered(input logic [63:0] a, b, input bit mx);
    real ra, rb;
    bit a_less;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    a_less = (ra < rb) || (ra == rb && a[63] && !b[63]);
    return mx ? (a_less ? b : a) : (a_less ? a : b);
  endfunction
  function automatic logic [63:0] ref_model(input logic [63:0] a, b, input logic [3:0] m);
    bit mx, an, bn;
    real ma, mb;
    logic [63:0] r;
    mx = m[3];
    an = is_nan(a);
    bn = is_nan(b);
    ma = $bitstoreal({1'b0, a[62:0]});
    mb = $bitstoreal({1'b0, b[62:0]});
    if (m[2] && !an && !bn && ma != mb) begin
      r = (mx ? (ma > mb) : (ma < mb)) ? a : b;
    end else begin
      case (m[1:0])
        2'b11: begin
          if (an || bn) r = b;
          else if (mx) r = ($bitstoreal(a) > $bitstoreal(b)) ? a : b;
          else         r = ($bitstoreal(a) < $bitstoreal(b)) ? a : b;
        end
        2'b01: r = an ? a : (bn ? b : ordered(a, b, mx));
        2'b00: begin
          if (is_snan(a))     r = a;
          else if (is_snan(b)) r = b;
          else if (an && bn)  r = a;
          else if (an)        r = b;
          else if (bn)        r = a;
          else                r = ordered(a, b, mx);
        end
        default: begin
          if (an && bn) r = a;
          else if (an)  r = b;
          else if (bn)  r = a;
          else          r = ordered(a, b, mx);
        end
      endcase
    end
    return quiet(r);
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] a, b, input logic [3:0] m, output logic [63:0] r);
    @(negedge clk);
    a_i = a; b_i = b; mode_i = m; valid_i = 1'b1;
    @(posedge clk);
    #1;
    r = result_o;
  endtask

  task automatic op_check(input string tag, input logic [63:0] a, b,
                          input logic [3:0] m, input logic [63:0] exp);
    logic [63:0] r;
    run_op(a, b, m, r);
    check(tag, r, exp);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check("R11 result after reset", result_o, 64'h0);
    check("R11 valid after reset", {63'h0, valid_o}, 64'h0);
  endtask

  task automatic t_cstyle;
    op_check("R1 cmin ordinary", P1, P2, 4'b0011, P1);
    op_check("R1 cmax ordinary", P1, P2, 4'b1011, P2);
    op_check("R1 cmin nan A gives B", QNAN, P1, 4'b0011, P1);
    op_check("R1 cmin nan B gives B", P1, QNAN, 4'b0011, QNAN);
    op_check("R1 cmin -0,+0 gives B", N0, P0, 4'b0011, P0);
    op_check("R1 cmin +0,-0 gives B", P0, N0, 4'b0011, N0);
  endtask

  task automatic t_num08;
    op_check("R2 min -0 below +0", P0, N0, 4'b0000, N0);
    op_check("R2 max +0 above -0", N0, P0, 4'b1000, P0);
    op_check("R2 qnan A gives B", QNAN, P2, 4'b0000, P2);
    op_check("R2 snan A quieted", SNAN, P2, 4'b0000, 64'h7FF8000000000001);
    op_check("R2 snan B quieted", P2, SNN, 4'b1000, 64'hFFFC000000000000);
    op_check("R2 two qnan gives A", QNP, QNAN, 4'b0000, QNP);
  endtask

  task automatic t_min19;
    op_check("R3 min nan B propagates", P1, QNAN, 4'b0001, QNAN);
    op_check("R3 max snan A propagates", SNAN, P2, 4'b1001, 64'h7FF8000000000001);
    op_check("R3 min -0 below +0", P0, N0, 4'b0001, N0);
    op_check("R3 max +0 above -0", N0, P0, 4'b1001, P0);
  endtask

  task automatic t_num19;
    op_check("R4 snan A gives B", SNAN, P2, 4'b0010, P2);
    op_check("R4 qnan A gives -inf", QNAN, NINF, 4'b1010, NINF);
    op_check("R4 both nan gives A", SNAN, QNAN, 4'b0010, 64'h7FF8000000000001);
    op_check("R4 min -0 below +0", P0, N0, 4'b0010, N0);
  endtask

  task automatic t_mag;
    op_check("R5 minmag c", N3, P2, 4'b0111, P2);
    op_check("R5 maxmag c", N3, P2, 4'b1111, N3);
    op_check("R5 minmag inf", NINF, P1, 4'b0101, P1);
    op_check("R5 maxmag inf", P1, NINF, 4'b1100, NINF);
  endtask

  task automatic t_mag_tie;
    op_check("R6 tie min num08", P3, N3, 4'b0100, N3);
    op_check("R6 tie max num08", N3, P3, 4'b1100, P3);
    op_check("R6 tie zero c-style", N0, P0, 4'b0111, P0);
    op_check("R6 tie zero max19", N0, P0, 4'b1101, P0);
  endtask

  task automatic t_mag_nan;
    op_check("R7 nan fallback num19", QNAN, P2, 4'b0110, P2);
    op_check("R7 nan fallback min19", P2, QNAN, 4'b0101, QNAN);
    op_check("R7 nan fallback c min", QNAN, P2, 4'b0111, P2);
    op_check("R7 snan fallback c max", P2, SNAN, 4'b1111, 64'h7FF8000000000001);
  endtask

  task automatic t_quiet;
    op_check("R8 payload kept", 64'h7FF0000000000ABC, P1, 4'b0001, 64'h7FF8000000000ABC);
    op_check("R8 negative snan", P1, SNN, 4'b1101, 64'hFFFC000000000000);
  endtask

  task automatic t_timing;
    logic [63:0] r;
    run_op(P3, P1, 4'b1011, r);
    check("R9 result with valid", r, P3);
    check("R9 valid_o after strobe", {63'h0, valid_o}, 64'h1);
    @(negedge clk);
    valid_i = 1'b0; a_i = NINF; b_i = QNAN; mode_i = 4'b0001;
    @(posedge clk);
    #1;
    check("R9 valid_o drops", {63'h0, valid_o}, 64'h0);
    check("R10 result held while idle", result_o, P3);
    @(posedge clk);
    #1;
    check("R10 result still held", result_o, P3);
  endtask

  task automatic t_sweep;
    logic [63:0] vals [12];
    logic [63:0] r;
    vals = '{P0, N0, P1, P2, P3, N3, PINF, NINF, QNAN, QNP, SNAN, SNN};
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          run_op(vals[i], vals[j], 4'(m), r);
          check($sformatf("R1 sweep mode %0d pair %0d,%0d", m, i, j), r,
                ref_model(vals[i], vals[j], 4'(m)));
        end
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_cstyle();
    t_num08();
    t_min19();
    t_num19();
    t_mag();
    t_mag_tie();
    t_mag_nan();
    t_quiet();
    t_timing();
    t_sweep();
    @(negedge clk);
    valid_i = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule